// File: doc/BRIEF.md
# Burst Serial Port with Eight-Slot Byte Buffer

This block is a clock-synchronous serial channel that moves a burst of one to eight bytes through its pins with no processor involvement per byte. Software loads the outgoing bytes into an eight-slot, eight-bit buffer through a simple indexed write port. It sets the burst length, the bit order and the clock source, then pulses `start`. The block shifts every byte out on `sdo` and captures the same number of bytes from `sdi`. Each captured byte replaces the slot it was sent from, so a completed burst leaves the reply in the buffer, readable through the indexed read port.

The serial clock can come from the block itself or from a remote master. An optional select-gated mode lets an active-low select input pause the burst and release the clock and data drivers while the select is inactive. An optional strobe output marks the end of a burst, for example to load an external shift register.

Top module: `fifo_burst_sio`

## Requirements
- R1: The buffer holds 8 slots of 8 bits. While `busy` is low, `wr_en` stores `wr_data` into slot `wr_idx`. `rd_data` always shows slot `rd_idx` in the same cycle. A write while `busy` is high is ignored.
- R2: A burst sends slots 0, 1, … in ascending order. `start_count` sets the byte count: 0 runs 1 byte, 1 to 8 run that many bytes, and 9 to 15 run 8 bytes.
- R3: If `lsb_first` is 0, each byte goes out bit 7 first. If it is 1, bit 0 goes first. A received bit is stored at the same bit position as the bit sent in that slot.
- R4: With the internal clock (`ext_clk` = 0), `sck_o` idles high. Each bit takes 8 clock cycles: 4 low, then 4 high. The first low phase begins in the cycle after a start is accepted. `sdo` changes when `sck_o` falls, and `sdi` is sampled when `sck_o` rises.
- R5: Once the eighth bit of byte k has been sampled, the received byte replaces slot k.
- R6: `busy` rises in the cycle after a start is accepted. `busy` falls and `done` rises together, in the cycle after the last sampling edge of the final byte. `done` stays high until the next accepted start clears it. `busy` and `done` are never high together.
- R7: A `start` while `busy` is high is ignored, and the burst in progress continues unchanged.
- R8: With `ext_clk` = 1, `sck_oe` is low. `sck_i` passes through a 2-flop synchroniser. Its rising edges sample `sdi` and its falling edges advance `sdo`.
- R9: With `cs_gate` = 1, a high `cs_n` (seen through a 2-flop synchroniser) freezes the burst and drives `sdo_oe` and `sck_oe` low. A low `cs_n` resumes the burst.
- R10: If `latch_en` was set at start, `latch_o` goes high in the same cycle that `done` rises and stays high for exactly 8 cycles (one internal clock period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | 3 | Slot written |
| wr_data | input | 8 | Byte written |
| rd_idx | input | 3 | Slot read |
| rd_data | output | 8 | Contents of slot `rd_idx` |
| start | input | 1 | Begin a burst (ignored while busy) |
| start_count | input | 4 | Requested byte count |
| lsb_first | input | 1 | Bit order select |
| ext_clk | input | 1 | 1: serial clock taken from `sck_i` |
| cs_gate | input | 1 | Enable select-gated operation |
| latch_en | input | 1 | Enable the end-of-burst strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| cs_n | input | 1 | Active-low select |
| latch_o | output | 1 | End-of-burst strobe |

## Verification
A wrong phase count or bit index in this block shows on `sck_o` or `sdo` within one 8-cycle bit period. To catch it, the bench predicts every pin cycle by cycle and compares on every clock during internal-clock bursts. A wrong slot pointer or bit-position mapping shows first on `sdo` and later in the bytes read back after the burst. An error in the end-of-burst logic shows as `done`, `busy` or `latch_o` changing one cycle early or late.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SLOTS  = 8;
    localparam int unsigned IDX_W  = $clog2(SLOTS);
    localparam int unsigned BIT_W  = $clog2(BYTE_W);
    localparam int unsigned CNT_W  = IDX_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BIT_W-1:0]  bitpos_t;

    // Settings captured when a burst is accepted
    typedef struct packed {
        logic lsb_first;
        logic latch_en;
        idx_t last_slot;
    } burst_cfg_t;

    // Requested count mapped to the index of the final slot
    function automatic idx_t last_slot_of(input logic [CNT_W-1:0] req);
        if (req == '0)
            return '0;
        if (req >= CNT_W'(SLOTS))
            return idx_t'(SLOTS - 1);
        return idx_t'(req - 1'b1);
    endfunction

    // Position inside a byte of the k-th bit on the wire
    function automatic bitpos_t wire_pos(input logic lsb, input bitpos_t k);
        return lsb ? k : bitpos_t'(BYTE_W - 1) - k;
    endfunction

endpackage

// File: rtl/sio_slot_bank.sv
module sio_slot_bank
    import sio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  cpu_we,
    input  idx_t  cpu_widx,
    input  byte_t cpu_wdata,
    input  idx_t  cpu_ridx,
    output byte_t cpu_rdata,
    input  logic  eng_we,
    input  idx_t  eng_widx,
    input  byte_t eng_wdata,
    input  idx_t  eng_ridx,
    output byte_t eng_rdata
);

    byte_t slot_q [SLOTS];
    logic [SLOTS*BYTE_W-1:0] flat;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (eng_we && eng_widx == idx_t'(g))
                slot_q[g] <= eng_wdata;
            else if (cpu_we && !busy && cpu_widx == idx_t'(g))
                slot_q[g] <= cpu_wdata;
        end
        assign flat[g*BYTE_W +: BYTE_W] = slot_q[g];
    end

    assign cpu_rdata = slot_q[cpu_ridx];
    assign eng_rdata = slot_q[eng_ridx];

    // R1: host writes during a burst leave the buffer untouched
    assert_no_cpu_write_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_we && !eng_we) |=> $stable(flat));

endmodule

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
    parameter int unsigned HALF   = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_mode,
    input  logic run,
    input  logic arm,
    input  logic sck_pin,
    output logic sck_drive,
    output logic rise_ev,
    output logic fall_ev
);

    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned PH_W   = $clog2(PERIOD);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_FALL = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] ph_q;
    logic            sck_q;
    logic [SYNC_N:0] sync_q;   // SYNC_N stages plus one history flop

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_N-1:0], sck_pin};
    end

    logic ext_rise, ext_fall, int_rise, int_fall;
    assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign ext_fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];
    assign int_rise = (ph_q == PH_RISE);
    assign int_fall = (ph_q == PH_FALL);

    assign rise_ev = run && (ext_mode ? ext_rise : int_rise);
    assign fall_ev = run && (ext_mode ? ext_fall : int_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            sck_q <= 1'b1;
        end else if (arm) begin
            ph_q  <= '0;
            sck_q <= ext_mode;
        end else if (run && !ext_mode) begin
            ph_q <= int_fall ? '0 : ph_q + 1'b1;
            if (int_rise) sck_q <= 1'b1;
            if (int_fall) sck_q <= 1'b0;
        end
    end

    assign sck_drive = sck_q;

    // R9: a paused or idle generator keeps its clock level
    assert_sck_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !arm) |=> $stable(sck_q));

    // R4: internal clock goes high after its low phase
    assert_sck_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !ext_mode && !arm && !sck_q && ph_q == PH_RISE) |=> $rose(sck_q));

endmodule

// File: rtl/sio_burst_ctrl.sv
module sio_burst_ctrl
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_lsb,
    input  logic             req_latch,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             sdi,
    input  byte_t            tx_byte,
    output logic             busy,
    output logic             done,
    output logic             finish,
    output logic             arm,
    output idx_t             fetch_slot,
    output logic             store_en,
    output idx_t             store_slot,
    output byte_t            store_byte,
    output logic             sdo,
    output logic             latch_sel
);

    burst_cfg_t cfg_q;
    idx_t       slot_q;
    bitpos_t    bit_q;
    byte_t      rx_q, rx_next;
    logic       busy_q, done_q, sdo_q;
    bitpos_t    cur_pos;
    logic       byte_end;

    assign arm      = start && !busy_q;
    assign cur_pos  = wire_pos(cfg_q.lsb_first, bit_q);
    assign byte_end = busy_q && rise_ev && (bit_q == '1);
    assign finish   = byte_end && (slot_q == cfg_q.last_slot);

    always_comb begin
        rx_next          = rx_q;
        rx_next[cur_pos] = sdi;
    end

    assign fetch_slot = arm ? '0 : slot_q;
    assign store_en   = byte_end;
    assign store_slot = slot_q;
    assign store_byte = rx_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            slot_q <= '0;
            bit_q  <= '0;
            rx_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sdo_q  <= 1'b0;
        end else if (arm) begin
            cfg_q  <= '{lsb_first: req_lsb, latch_en: req_latch,
                        last_slot: last_slot_of(req_count)};
            slot_q <= '0;
            bit_q  <= '0;
            rx_q   <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
            sdo_q  <= tx_byte[wire_pos(req_lsb, '0)];
        end else if (busy_q) begin
            if (rise_ev) begin
                rx_q  <= rx_next;
                bit_q <= bit_q + 1'b1;
                if (byte_end) slot_q <= slot_q + 1'b1;
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
            if (fall_ev)
                sdo_q <= tx_byte[cur_pos];
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign sdo       = sdo_q;
    assign latch_sel = cfg_q.latch_en;

    // R6: completion and activity never overlap
    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(busy_q && done_q));

    // R7: a start during a burst changes neither activity nor settings
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && !finish) |=> (busy_q && $stable(cfg_q)));

    // R6: completion is raised exactly by the final sampling edge
    assert_done_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(finish));

endmodule

// File: rtl/sio_strobe.sv
module sio_strobe #(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic enable,
    output logic strobe
);

    localparam int unsigned CW = $clog2(WIDTH + 1);

    logic [CW-1:0] left_q;
    logic          on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            left_q <= '0;
        end else if (fire && enable) begin
            on_q   <= 1'b1;
            left_q <= CW'(WIDTH - 1);
        end else if (on_q) begin
            if (left_q == '0) on_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign strobe = on_q;

    // R10: strobe begins right after the firing cycle
    assert_strobe_start_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && enable) |=> strobe);

    // R10: the high time never exceeds WIDTH cycles
    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)         run_len <= '0;
        else if (strobe) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end
    assert_strobe_width_R10: assert property (@(posedge clk) disable iff (rst)
        run_len <= (CW+1)'(WIDTH));

endmodule

// File: rtl/fifo_burst_sio.sv
module fifo_burst_sio
    import sio_pkg::*;
#(
    parameter int unsigned SCK_HALF = 4,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic             lsb_first,
    input  logic             ext_clk,
    input  logic             cs_gate,
    input  logic             latch_en,
    output logic             busy,
    output logic             done,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sdi,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             cs_n,
    output logic             latch_o
);

    localparam int unsigned STROBE_LEN = 2 * SCK_HALF;

    // select synchroniser, idles deselected
    logic [SYNC_N-1:0] cs_sync_q;
    always_ff @(posedge clk) begin
        if (rst) cs_sync_q <= '1;
        else     cs_sync_q <= {cs_sync_q[SYNC_N-2:0], cs_n};
    end

    logic hold, run, arm, finish, rise_ev, fall_ev;
    logic eng_we, latch_sel;
    idx_t fetch_slot, store_slot;
    byte_t tx_byte, store_byte;

    assign hold = cs_gate && cs_sync_q[SYNC_N-1];
    assign run  = busy && !hold;

    sio_slot_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cpu_we    (wr_en),
        .cpu_widx  (wr_idx),
        .cpu_wdata (wr_data),
        .cpu_ridx  (rd_idx),
        .cpu_rdata (rd_data),
        .eng_we    (eng_we),
        .eng_widx  (store_slot),
        .eng_wdata (store_byte),
        .eng_ridx  (fetch_slot),
        .eng_rdata (tx_byte)
    );

    sio_sck_gen #(.HALF(SCK_HALF), .SYNC_N(SYNC_N)) u_sck (
        .clk       (clk),
        .rst       (rst),
        .ext_mode  (ext_clk),
        .run       (run),
        .arm       (arm),
        .sck_pin   (sck_i),
        .sck_drive (sck_o),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev)
    );

    sio_burst_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_count  (start_count),
        .req_lsb    (lsb_first),
        .req_latch  (latch_en),
        .rise_ev    (rise_ev),
        .fall_ev    (fall_ev),
        .sdi        (sdi),
        .tx_byte    (tx_byte),
        .busy       (busy),
        .done       (done),
        .finish     (finish),
        .arm        (arm),
        .fetch_slot (fetch_slot),
        .store_en   (eng_we),
        .store_slot (store_slot),
        .store_byte (store_byte),
        .sdo        (sdo),
        .latch_sel  (latch_sel)
    );

    sio_strobe #(.WIDTH(STROBE_LEN)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .fire   (finish),
        .enable (latch_sel),
        .strobe (latch_o)
    );

    assign sck_oe = !ext_clk && !hold;
    assign sdo_oe = !hold;

    // R9: while paused by the select, no serial edge reaches the engine
    assert_paused_no_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && hold) |-> !(rise_ev || fall_ev));

    // R10: the strobe rises together with completion
    assert_strobe_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |-> $rose(done));

endmodule

// File: tb/fifo_burst_sio_tb.sv
`timescale 1ns/1ps
module fifo_burst_sio_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       wr_en = 0, start = 0, lsb_first = 0, ext_clk = 0, cs_gate = 0, latch_en = 0;
    logic [2:0] wr_idx = 0, rd_idx = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [3:0] start_count = 0;
    logic       sck_i = 1, sdi = 0, cs_n = 1;
    logic       busy, done, sck_o, sck_oe, sdo, sdo_oe, latch_o;

    fifo_burst_sio u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .start(start), .start_count(start_count),
        .lsb_first(lsb_first), .ext_clk(ext_clk), .cs_gate(cs_gate), .latch_en(latch_en),
        .busy(busy), .done(done), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cs_n(cs_n), .latch_o(latch_o)
    );

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [7:0] model_mem [8];

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic wire_bit(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    function automatic int clamp(input int c);
        if (c == 0) return 1;
        if (c > 8) return 8;
        return c;
    endfunction

    task automatic host_write(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 0;
        if (!busy) model_mem[idx] = v;
    endtask

    task automatic check_mem(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.1;
            chk(req, "slot readback", 32'(rd_data), 32'(model_mem[i]));
        end
    endtask

    // Internal-clock burst compared against a per-cycle model on every clock
    task automatic burst_internal(input int req, input logic lsb, input logic lat,
                                  input logic poke, input logic [7:0] seed);
        int n, tend;
        logic [7:0] tx [8];
        logic [7:0] rx [8];
        n = clamp(req);
        tend = 64 * n - 4;
        for (int i = 0; i < 8; i++) begin
            tx[i] = model_mem[i];
            rx[i] = seed ^ 8'(i * 29);
        end
        @(negedge clk);
        start = 1; start_count = 4'(req); lsb_first = lsb; latch_en = lat;
        sdi = 0;
        @(posedge clk);
        for (int t = 0; t <= tend + 12; t++) begin
            int b;
            logic e_sck, e_sdo;
            @(negedge clk);
            start = 0; wr_en = 0;
            b = (t < tend) ? t / 8 : 8 * n - 1;
            e_sck = (t < tend) ? ((t % 8) >= 4) : 1'b1;
            e_sdo = wire_bit(tx[b / 8], b % 8, lsb);
            chk("R4", "sck_o", 32'(sck_o), 32'(e_sck));
            chk("R3", "sdo", 32'(sdo), 32'(e_sdo));
            chk("R6", "busy", 32'(busy), 32'(t < tend));
            chk("R6", "done", 32'(done), 32'(t >= tend));
            chk("R10", "latch_o", 32'(latch_o), 32'(lat && t >= tend && t < tend + 8));
            if (t < tend) sdi = wire_bit(rx[t / 8 / 8], (t / 8) % 8, lsb);
            if (poke && t == 10) begin
                // R7: new start ignored; R1: write ignored while busy
                start = 1; start_count = 4'd2; lsb_first = ~lsb;
                wr_en = 1; wr_idx = 3'(n - 1); wr_data = ~tx[n - 1];
            end
            if (poke && t == 11) lsb_first = lsb;
        end
        for (int i = 0; i < n; i++) model_mem[i] = rx[i];   // R5
        check_mem("R5");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model_mem[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk("R6", "busy after reset", 32'(busy), 0);
        chk("R6", "done after reset", 32'(done), 0);
        chk("R4", "sck idle high", 32'(sck_o), 1);
        chk("R10", "latch idle", 32'(latch_o), 0);
        check_mem("R1");

        // R1: host writes and readback
        for (int i = 0; i < 8; i++) host_write(i, 8'h3C ^ 8'(i * 71));
        check_mem("R1");

        // R2 R3 R4: three bytes, msb first, no strobe
        burst_internal(3, 1'b0, 1'b0, 1'b0, 8'hA5);
        // R2 clamp of 0 to one byte, lsb first, R10 strobe
        burst_internal(0, 1'b1, 1'b1, 1'b0, 8'h5E);
        // R2 clamp of 12 to eight bytes, R7 and R1 pokes while busy
        burst_internal(12, 1'b0, 1'b1, 1'b1, 8'hC3);

        // R9: select-gated pause
        @(negedge clk);
        cs_gate = 1; cs_n = 1; sdi = 1;
        repeat (3) @(negedge clk);
        chk("R9", "sdo_oe deselected", 32'(sdo_oe), 0);
        chk("R9", "sck_oe deselected", 32'(sck_oe), 0);
        start = 1; start_count = 4'd1; lsb_first = 0; latch_en = 0;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        chk("R9", "busy frozen", 32'(busy), 1);
        chk("R9", "sck frozen low", 32'(sck_o), 0);
        cs_n = 0;
        repeat (4) @(negedge clk);
        chk("R9", "sdo_oe selected", 32'(sdo_oe), 1);
        chk("R9", "sck_oe selected", 32'(sck_oe), 1);
        repeat (70) @(negedge clk);
        chk("R9", "done after resume", 32'(done), 1);
        model_mem[0] = 8'hFF;
        check_mem("R9");
        cs_gate = 0; cs_n = 1;

        // R8: externally clocked burst of two bytes, msb first
        @(negedge clk);
        ext_clk = 1;
        #0.1;
        chk("R8", "sck_oe external", 32'(sck_oe), 0);
        begin
            logic [7:0] tx [2];
            logic [7:0] rx [2];
            tx[0] = model_mem[0]; tx[1] = model_mem[1];
            rx[0] = 8'h96; rx[1] = 8'h2B;
            start = 1; start_count = 4'd2; lsb_first = 0;
            @(negedge clk);
            start = 0;
            for (int b = 0; b < 16; b++) begin
                sck_i = 0;
                sdi = wire_bit(rx[b / 8], b % 8, 1'b0);
                repeat (8) @(negedge clk);
                chk("R8", "sdo on external clock", 32'(sdo), 32'(wire_bit(tx[b / 8], b % 8, 1'b0)));
                if (b == 15) chk("R8", "busy before last rise", 32'(busy), 1);
                sck_i = 1;
                repeat (8) @(negedge clk);
            end
            chk("R8", "done external", 32'(done), 1);
            chk("R8", "busy external", 32'(busy), 0);
            model_mem[0] = rx[0]; model_mem[1] = rx[1];
            check_mem("R8");
        end
        ext_clk = 0;

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule